// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home side of a directory-based coherence scheme for a small distributed-memory machine. For every memory block whose address it owns, it keeps a directory record: a state (invalid, shared or exclusive), a bit vector of nodes that hold a clean copy, and the ID of the single owner when the block is held dirty. A requesting node sends a read or a write request. The controller looks up the record and sends point-to-point coherence messages to the exact nodes that hold copies. These messages are invalidates, fetches from a dirty owner, or fetch-and-invalidate. The controller counts the acknowledgements that come back. It replies to the requester with the block data only after all coherence work for that request is done.

Memory holds stale data while a block is exclusive, so a read or write of a block owned by another node first pulls the current data from that owner. On a fetch, the returned data is written back into the home memory. The engine serves one transaction at a time. Any request that arrives while a transaction is open gets a negative acknowledgement, and the requester is expected to retry.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset no response, message or negative acknowledgement is valid, every block is invalid, and block k holds the value INIT_BASE + k in home memory.
- R2: A read of an invalid or shared block returns rsp_kind 1 (data) with the home memory word and sends no message. The requester is added to the sharer set.
- R3: A read of a block that another node holds exclusive sends exactly one message with msg_kind 2 (fetch) to the owner. When the owner's acknowledgement arrives, its data is written to home memory and returned as rsp_kind 1. The block becomes shared by both the old owner and the requester.
- R4: A write to a shared block sends msg_kind 1 (invalidate) to every sharer except the requester, one per cycle, in ascending node order. The reply (rsp_kind 1) is issued only after one acknowledgement per invalidate has arrived. The requester then becomes the exclusive owner.
- R5: A write to an invalid block, or to a shared block whose only sharer is the requester, replies at once with rsp_kind 1 and the memory word, sends no message, and makes the requester the exclusive owner.
- R6: A write to a block that another node holds exclusive sends one msg_kind 3 (fetch-and-invalidate) to that owner. It replies with the returned data, and the requester becomes the new owner.
- R7: A read or write by the current exclusive owner of its own block returns rsp_kind 2 (already owned), sends no message and leaves the directory record unchanged.
- R8: A request sampled while a transaction is open raises nack_valid with nack_node equal to the requester on the next cycle. The request is dropped and changes no directory record.
- R9: Every coherence message carries the requested block address on msg_addr, and no message is ever addressed to the requesting node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read |
| req_node | input | NODE_W | ID of the requesting node |
| req_addr | input | ADDR_W | Block index |
| ack_valid | input | 1 | Acknowledgement from a remote node |
| ack_data | input | DATA_W | Block data carried by a fetch acknowledgement |
| rsp_valid | output | 1 | Reply to the requester is valid |
| rsp_kind | output | 2 | 1 = data, 2 = already owned |
| rsp_node | output | NODE_W | Requester the reply is for |
| rsp_data | output | DATA_W | Block data of a data reply |
| msg_valid | output | 1 | Coherence message is valid |
| msg_kind | output | 2 | 1 = invalidate, 2 = fetch, 3 = fetch-and-invalidate |
| msg_node | output | NODE_W | Destination remote node |
| msg_addr | output | ADDR_W | Block the message refers to |
| nack_valid | output | 1 | Negative acknowledgement (retry) |
| nack_node | output | NODE_W | Node that must retry |

## Verification
The bench builds the block with the default NODES = 8, ADDR_W = 4 and DATA_W = 32. With these values the full node ID range, the ascending invalidate order across non-adjacent sharers, and several independent blocks in different states are all reachable in a short run. A remote-node model answers each message on the following cycle and returns node- and address-dependent data on fetches. As a result, a reply that carries the stale memory word instead of the owner's data shows up as a mismatch. The busy-retry case is exercised by a second request issued during an open fetch. A later read then confirms that the refused write left no trace.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    D_INV = 2'd0,
    D_SHR = 2'd1,
    D_EXC = 2'd2
  } dir_state_e;

  localparam logic [1:0] MSG_INV   = 2'd1;
  localparam logic [1:0] MSG_FETCH = 2'd2;
  localparam logic [1:0] MSG_FINV  = 2'd3;

  localparam logic [1:0] RSP_DATA  = 2'd1;
  localparam logic [1:0] RSP_OWNED = 2'd2;
endpackage

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NODES  = 8,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output dir_state_e        rd_state,
  output logic [NODES-1:0]  rd_sharers,
  output logic [NODE_W-1:0] rd_owner,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  dir_state_e        wr_state,
  input  logic [NODES-1:0]  wr_sharers,
  input  logic [NODE_W-1:0] wr_owner
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ENT_W = 2 + NODES + NODE_W;

  logic [ENT_W-1:0] ram [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [DEPTH-1:0] vld;
  logic             rd_v;

  // record storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= {wr_state, wr_sharers, wr_owner};
    rd_q <= ram[rd_addr];
  end

  // per-entry written flags give a one-cycle reset of the whole table
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      rd_v <= 1'b0;
    end else begin
      if (wr_en) vld[wr_addr] <= 1'b1;
      rd_v <= vld[rd_addr];
    end
  end

  assign rd_state   = rd_v ? dir_state_e'(rd_q[ENT_W-1 -: 2]) : D_INV;
  assign rd_sharers = rd_q[NODE_W +: NODES];
  assign rd_owner   = rd_q[NODE_W-1:0];
endmodule

// File: rtl/blk_mem.sv
module blk_mem #(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] INIT_BASE = 32'h1000_0000
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = DATA_W'(INIT_BASE + 32'(k));
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/inv_walker.sv
module inv_walker #(
  parameter int NODES  = 8,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NODES-1:0]  load_vec,
  input  logic [1:0]        load_kind,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic              busy
);
  logic [NODES-1:0]  vec_q;
  logic [NODE_W-1:0] low_idx;
  logic              found;

  // lowest pending target goes first
  always_comb begin
    low_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NODES; i++) begin
      if (vec_q[i] && !found) begin
        low_idx = NODE_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q     <= '0;
      msg_valid <= 1'b0;
      msg_kind  <= '0;
      msg_node  <= '0;
    end else if (load) begin
      vec_q     <= load_vec;
      msg_kind  <= load_kind;
      msg_valid <= 1'b0;
    end else if (found) begin
      msg_valid       <= 1'b1;
      msg_node        <= low_idx;
      vec_q[low_idx]  <= 1'b0;
    end else begin
      msg_valid <= 1'b0;
    end
  end

  assign busy = |vec_q;
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int          NODES     = 8,
  parameter int          NODE_W    = $clog2(NODES),
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] INIT_BASE = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [NODE_W-1:0] req_node,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ack_valid,
  input  logic [DATA_W-1:0] ack_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [NODE_W-1:0] rsp_node,
  output logic [DATA_W-1:0] rsp_data,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic [ADDR_W-1:0] msg_addr,
  output logic              nack_valid,
  output logic [NODE_W-1:0] nack_node
);
  localparam int PEND_W = $clog2(NODES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_SEND} eng_e;

  eng_e              st;
  logic              cur_write, cur_fetch;
  logic [NODE_W-1:0] cur_node, cur_owner;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] held_data;
  logic [PEND_W-1:0] pend;

  dir_state_e        rd_state, dir_wst;
  logic [NODES-1:0]  rd_sharers, dir_wsh;
  logic [NODE_W-1:0] rd_owner, dir_wown;
  logic              dir_we;
  logic [DATA_W-1:0] mem_rd;
  logic              mem_we;

  logic              wk_load, wk_busy;
  logic [NODES-1:0]  wk_vec;
  logic [1:0]        wk_kind;
  logic              finish, owned, go_send;
  logic [PEND_W-1:0] pend_init;
  logic [NODES-1:0]  req_oh, others;
  logic              eng_busy, in_send;

  assign eng_busy = (st != S_IDLE);
  assign in_send  = (st == S_SEND);
  assign req_oh   = NODES'(1) << cur_node;
  assign others   = rd_sharers & ~req_oh;
  assign mem_we   = in_send && ack_valid && cur_fetch && (pend != '0);

  dir_table #(.ADDR_W(ADDR_W), .NODES(NODES), .NODE_W(NODE_W)) u_tab (
    .clk(clk), .rst(rst), .rd_addr(req_addr),
    .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_owner(rd_owner),
    .wr_en(dir_we), .wr_addr(cur_addr),
    .wr_state(dir_wst), .wr_sharers(dir_wsh), .wr_owner(dir_wown)
  );

  blk_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_BASE(INIT_BASE)) u_mem (
    .clk(clk), .rd_addr(req_addr), .rd_data(mem_rd),
    .wr_en(mem_we), .wr_addr(cur_addr), .wr_data(ack_data)
  );

  inv_walker #(.NODES(NODES), .NODE_W(NODE_W)) u_walk (
    .clk(clk), .rst(rst), .load(wk_load), .load_vec(wk_vec),
    .load_kind(wk_kind), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_node(msg_node), .busy(wk_busy)
  );

  // decision logic: directory update, message fan-out, reply trigger
  always_comb begin
    dir_we    = 1'b0;
    dir_wst   = rd_state;
    dir_wsh   = rd_sharers;
    dir_wown  = rd_owner;
    wk_load   = 1'b0;
    wk_vec    = '0;
    wk_kind   = MSG_INV;
    finish    = 1'b0;
    owned     = 1'b0;
    go_send   = 1'b0;
    pend_init = '0;
    case (st)
      S_LOOK: begin
        if (rd_state == D_EXC && rd_owner == cur_node) begin
          owned = 1'b1;
        end else if (rd_state == D_EXC) begin
          wk_load   = 1'b1;
          wk_vec    = NODES'(1) << rd_owner;
          wk_kind   = cur_write ? MSG_FINV : MSG_FETCH;
          go_send   = 1'b1;
          pend_init = PEND_W'(1);
        end else if (!cur_write) begin
          dir_we  = 1'b1;
          dir_wst = D_SHR;
          dir_wsh = ((rd_state == D_SHR) ? rd_sharers : '0) | req_oh;
          finish  = 1'b1;
        end else if (rd_state == D_SHR && others != '0) begin
          wk_load   = 1'b1;
          wk_vec    = others;
          wk_kind   = MSG_INV;
          go_send   = 1'b1;
          pend_init = PEND_W'($countones(others));
        end else begin
          dir_we   = 1'b1;
          dir_wst  = D_EXC;
          dir_wsh  = req_oh;
          dir_wown = cur_node;
          finish   = 1'b1;
        end
      end
      S_SEND: begin
        if (pend == '0 && !wk_busy) begin
          dir_we = 1'b1;
          finish = 1'b1;
          if (!cur_write) begin
            dir_wst  = D_SHR;
            dir_wsh  = (NODES'(1) << cur_owner) | req_oh;
            dir_wown = cur_owner;
          end else begin
            dir_wst  = D_EXC;
            dir_wsh  = req_oh;
            dir_wown = cur_node;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cur_write  <= 1'b0;
      cur_fetch  <= 1'b0;
      cur_node   <= '0;
      cur_owner  <= '0;
      cur_addr   <= '0;
      held_data  <= '0;
      pend       <= '0;
      rsp_valid  <= 1'b0;
      rsp_kind   <= '0;
      rsp_node   <= '0;
      rsp_data   <= '0;
      nack_valid <= 1'b0;
      nack_node  <= '0;
    end else begin
      nack_valid <= req_valid && eng_busy;
      nack_node  <= req_node;
      rsp_valid  <= finish || owned;
      rsp_kind   <= owned ? RSP_OWNED : RSP_DATA;
      rsp_node   <= cur_node;
      rsp_data   <= (st == S_LOOK) ? mem_rd : held_data;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            cur_write <= req_write;
            cur_node  <= req_node;
            cur_addr  <= req_addr;
            st        <= S_LOOK;
          end
        end
        S_LOOK: begin
          held_data <= mem_rd;
          cur_owner <= rd_owner;
          cur_fetch <= (rd_state == D_EXC);
          pend      <= pend_init;
          st        <= go_send ? S_SEND : S_IDLE;
        end
        S_SEND: begin
          if (ack_valid && pend != '0) begin
            pend <= pend - PEND_W'(1);
            if (cur_fetch) held_data <= ack_data;
          end
          if (finish) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign msg_addr = cur_addr;
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              eng_busy,
  input logic              in_send,
  input logic              nack_valid,
  input logic              rsp_valid,
  input logic              msg_valid,
  input logic [NODE_W-1:0] msg_node,
  input logic [NODE_W-1:0] cur_node
);
  p_nack_when_busy_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && eng_busy |=> nack_valid);

  p_no_nack_when_free_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && !eng_busy |=> !nack_valid);

  p_msg_not_to_requester_r9: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> msg_node != cur_node);

  p_msg_only_while_sending_r4: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> in_send);

  p_reply_after_messages_r4: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && msg_valid));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NODE_W(NODE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .eng_busy(eng_busy),
  .in_send(in_send), .nack_valid(nack_valid), .rsp_valid(rsp_valid),
  .msg_valid(msg_valid), .msg_node(msg_node), .cur_node(cur_node)
);

// File: tb/dir_home_ctrl_test.sv
`timescale 1ns/1ps
module dir_home_ctrl_test;
  localparam int NODES = 8;
  localparam int NW    = 3;
  localparam int AW    = 4;
  localparam int DW    = 32;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [NW-1:0] req_node = '0;
  logic [AW-1:0] req_addr = '0;
  logic ack_valid = 1'b0;
  logic [DW-1:0] ack_data = '0;
  logic rsp_valid; logic [1:0] rsp_kind; logic [NW-1:0] rsp_node; logic [DW-1:0] rsp_data;
  logic msg_valid; logic [1:0] msg_kind; logic [NW-1:0] msg_node; logic [AW-1:0] msg_addr;
  logic nack_valid; logic [NW-1:0] nack_node;

  always #5 clk = ~clk;

  dir_home_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_node(req_node), .req_addr(req_addr), .ack_valid(ack_valid),
    .ack_data(ack_data), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_node(rsp_node), .rsp_data(rsp_data), .msg_valid(msg_valid),
    .msg_kind(msg_kind), .msg_node(msg_node), .msg_addr(msg_addr),
    .nack_valid(nack_valid), .nack_node(nack_node)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [36:0] rspq[$];  string rsp_tag[$];
  logic [8:0]  msgq[$];  string msg_tag[$];
  logic [NW-1:0] nackq[$]; string nack_tag[$];
  logic [DW-1:0] ackq[$];

  function automatic logic [DW-1:0] owner_val(int node, int addr);
    return 32'hF000_0000 | DW'(node << 8) | DW'(addr);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_msg(int kind, int node, int addr, string tag);
    msgq.push_back({2'(kind), NW'(node), AW'(addr)});
    msg_tag.push_back(tag);
  endtask

  task automatic pulse(bit w, int node, int addr);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_node = NW'(node); req_addr = AW'(addr);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (rspq.size() != 0 || msgq.size() != 0 || nackq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_req(bit w, int node, int addr, int kind, logic [DW-1:0] data, string tag);
    rspq.push_back({2'(kind), NW'(node), data});
    rsp_tag.push_back(tag);
    pulse(w, node, addr);
    drain();
  endtask

  // monitor and remote-node model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (rsp_valid) begin
          if (rspq.size() == 0) check(1'b0, "unexpected reply", {rsp_kind, rsp_node}, 0);
          else begin
            logic [36:0] e; string t;
            e = rspq.pop_front(); t = rsp_tag.pop_front();
            check(rsp_kind == e[36:35], {t, " kind"}, rsp_kind, e[36:35]);
            check(rsp_node == e[34:32], {t, " node"}, rsp_node, e[34:32]);
            if (e[36:35] == 2'd1) check(rsp_data == e[31:0], {t, " data"}, rsp_data, e[31:0]);
          end
        end
        if (msg_valid) begin
          if (msgq.size() == 0) check(1'b0, "unexpected message", {msg_kind, msg_node}, 0);
          else begin
            logic [8:0] m; string t;
            m = msgq.pop_front(); t = msg_tag.pop_front();
            check({msg_kind, msg_node} == m[8:4], {t, " msg kind/node"}, {msg_kind, msg_node}, m[8:4]);
            check(msg_addr == m[3:0], {t, " R9 msg addr"}, msg_addr, m[3:0]);
          end
          ackq.push_back((msg_kind == 2'd1) ? 32'h0 : owner_val(int'(msg_node), int'(msg_addr)));
        end
        if (nack_valid) begin
          if (nackq.size() == 0) check(1'b0, "unexpected nack", nack_node, 0);
          else begin
            logic [NW-1:0] n; string t;
            n = nackq.pop_front(); t = nack_tag.pop_front();
            check(nack_node == n, t, nack_node, n);
          end
        end
        if (ackq.size() != 0) begin
          ack_valid = 1'b1;
          ack_data  = ackq.pop_front();
        end else begin
          ack_valid = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_valid && !msg_valid && !nack_valid, "R1 idle after reset",
          {rsp_valid, msg_valid, nack_valid}, 0);

    // R1/R2: reads of an invalid then shared block, sharers 1,4,6
    do_req(0, 1, 3, 1, BASE + 3, "R1 R2 first read");
    do_req(0, 4, 3, 1, BASE + 3, "R2 shared read n4");
    do_req(0, 6, 3, 1, BASE + 3, "R2 shared read n6");

    // R4: write by sharer 4 invalidates 1 and 6 in order
    exp_msg(1, 1, 3, "R4 inv n1");
    exp_msg(1, 6, 3, "R4 inv n6");
    do_req(1, 4, 3, 1, BASE + 3, "R4 write grant");

    // R7: owner re-requests
    do_req(0, 4, 3, 2, '0, "R7 owner read");
    do_req(1, 4, 3, 2, '0, "R7 owner write");

    // R3: read of block owned by 4
    exp_msg(2, 4, 3, "R3 fetch");
    do_req(0, 2, 3, 1, owner_val(4, 3), "R3 fetched data");

    // R3/R4: both 2 and 4 now share it, memory holds fetched data
    exp_msg(1, 2, 3, "R3 R4 inv n2");
    exp_msg(1, 4, 3, "R3 R4 inv n4");
    do_req(1, 7, 3, 1, owner_val(4, 3), "R3 memory updated");

    // R6: write to block owned by 7
    exp_msg(3, 7, 3, "R6 fetch-inv");
    do_req(1, 0, 3, 1, owner_val(7, 3), "R6 new owner data");
    do_req(0, 0, 3, 2, '0, "R6 new owner is n0");

    // R5: write to invalid; write by sole sharer
    do_req(1, 5, 9, 1, BASE + 9, "R5 write invalid");
    do_req(0, 1, 12, 1, BASE + 12, "R5 prep read");
    do_req(1, 1, 12, 1, BASE + 12, "R5 sole sharer write");
    do_req(1, 1, 12, 2, '0, "R5 sole sharer now owner");

    // R8: second request during an open fetch
    exp_msg(2, 5, 9, "R8 fetch");
    rspq.push_back({2'd1, 3'd3, owner_val(5, 9)});
    rsp_tag.push_back("R8 first request data");
    nackq.push_back(3'd6);
    nack_tag.push_back("R8 nack node");
    pulse(0, 3, 9);
    req_valid = 1'b1; req_write = 1'b1; req_node = 3'd6; req_addr = 4'd9;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    // refused write left 6 without ownership: plain shared read, no messages
    do_req(0, 6, 9, 1, owner_val(5, 9), "R8 dropped request");

    check(rspq.size() == 0 && msgq.size() == 0 && nackq.size() == 0,
          "R9 all expected items seen", rspq.size() + msgq.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule